// File: doc/BRIEF.md
# DMA Minor-Loop Transfer Engine with Cancel

This block moves one minor loop of data for a single DMA channel. A start pulse loads a 32-bit byte-count descriptor word together with a source and a destination base address. The engine then issues alternating read and write beats of up to one data word each, until the programmed number of bytes has been copied. When the loop retires, a signed end-of-loop offset can be added to the source address, the destination address, or both. A one-cycle done pulse marks the end of the loop.

A mapping-mode input selects how the descriptor word is decoded. With mapping off, the whole word is the byte count. With mapping on, the top two bits enable the offset for each address side independently. When either of them is set, the middle bits carry a signed offset and the count shrinks to a short field.

Software can stop a running loop with either of two self-clearing cancel bits. Both take effect only once the write that closes the current read/write pair has been acknowledged, and the loop then retires as a normal loop would. The error flavour also latches an error status flag, which drives an error interrupt when the interrupt is enabled.

The controller has four states. IDLE waits for a start. READ holds a read request until it is acknowledged. WRITE holds a write request until it is acknowledged. FINISH lasts one cycle: it raises done, applies the offsets and honours any pending cancel. The transitions are:
- IDLE to READ on a start with a non-zero count.
- IDLE to FINISH on a start with a zero count.
- READ to WRITE on a read acknowledge.
- WRITE to READ on a write acknowledge when bytes remain and no cancel is pending.
- WRITE to FINISH on a write acknowledge when the count is used up or a cancel is pending.
- FINISH to IDLE unconditionally.

Top module: `mloop_dma`

## Requirements
- R1: After reset the engine is idle. It drives no read or write request, done is low, the busy flag is low, the error status and interrupt are low and both cancel bits read 0.
- R2: With map_en = 0, all 32 bits of desc_word are the byte count, and no offset is applied to either address at the end of the loop.
- R3: With map_en = 1, desc_word bit 31 enables the offset on the source address and bit 30 enables it on the destination address. When either enable is set, bits 29:10 hold a 20-bit two's-complement offset and bits 9:0 hold the byte count. At the end of the loop the offset is added to each enabled side only.
- R4: With map_en = 1 and both enables clear, bits 29:0 are the byte count and no offset is applied.
- R5: Each read beat is followed by one write beat of the same size to the destination, carrying the data that was read. A beat moves 4 bytes, or the remaining byte count if that is smaller. The size is given as a byte count on rd_size and wr_size. Both addresses advance by the bytes moved once the write is acknowledged.
- R6: A start with a byte count of 0 makes no bus request. It still pulses done on the cycle after the start and applies any enabled offset.
- R7: busy is high from the cycle after an accepted start until the cycle that carries the done pulse, inclusive. done is high for exactly one cycle per loop.
- R8: A normal cancel (cancel_set pulse, shown on cancel_pending bit 0) takes effect only after the next write acknowledge. The loop then retires with a done pulse and offsets, exactly as a finished loop would. The bit clears itself and no error is recorded.
- R9: An error cancel (err_cancel_set pulse, shown on cancel_pending bit 1) stops the loop at the same boundary and sets err_status. This includes a cancel that arrives with the final write acknowledge. err_irq equals err_status AND err_int_en. Both cancel bits clear once honoured.
- R10: A cancel bit set while the engine is idle reads 1 for one cycle and then clears, with no effect on a loop started later.
- R11: A start pulse while the engine is busy is ignored. The running loop keeps its count and addresses.
- R12: err_status stays set until an err_clr pulse. When setting and clearing fall in the same cycle, the flag stays set.
- R13: A read or write request, once raised, stays raised with a stable address until it is acknowledged, even when a cancel arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, sampled while idle |
| map_en | input | 1 | Descriptor decode mode: 0 plain count, 1 offset-capable |
| desc_word | input | 32 | Byte-count descriptor word |
| src_base | input | 32 | Source start address |
| dst_base | input | 32 | Destination start address |
| cancel_set | input | 1 | Write pulse that sets the normal cancel bit |
| err_cancel_set | input | 1 | Write pulse that sets the error cancel bit |
| err_clr | input | 1 | Write-one pulse that clears err_status |
| err_int_en | input | 1 | Error interrupt enable |
| rd_req | output | 1 | Read request |
| rd_addr | output | 32 | Read address |
| rd_size | output | 3 | Read size in bytes (1 to 4) |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | Write request |
| wr_addr | output | 32 | Write address |
| wr_size | output | 3 | Write size in bytes (1 to 4) |
| wr_data | output | 32 | Write data |
| wr_ack | input | 1 | Write acknowledge |
| busy | output | 1 | Loop in progress |
| done | output | 1 | One-cycle loop retire pulse |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| cancel_pending | output | 2 | Bit 1 error cancel, bit 0 normal cancel |
| err_status | output | 1 | Error status flag |
| err_irq | output | 1 | Error interrupt |

## Verification
Two pairs of events can land in the same cycle. An error cancel can arrive on the very edge that acknowledges the final write, so that natural completion and cancellation coincide. The bench provokes this by switching to immediate acknowledges and raising err_cancel_set on the cycle it answers the last write request. It then judges that the error is still logged and that no extra beat is issued. In the FINISH cycle of that same loop it also pulses err_clr, so that the error set and the error clear collide, and expects err_status to end up set. A behavioural reference model, stepped on every clock, judges both cases and every other cycle of the run.

// File: rtl/mloop_pkg.sv
package mloop_pkg;

    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WRITE  = 2'd2,
        ST_FINISH = 2'd3
    } mloop_state_e;

    typedef struct packed {
        logic              src_en;
        logic              dst_en;
        logic [ADDR_W-1:0] offset;
        logic [WORD_W-1:0] count;
    } mloop_desc_t;

endpackage

// File: rtl/mloop_desc_decode.sv
module mloop_desc_decode
    import mloop_pkg::*;
#(
    parameter int OFF_W   = 20,
    parameter int SHORT_W = 10
) (
    input  logic              map_en,
    input  logic [WORD_W-1:0] word,
    output mloop_desc_t       desc
);
    localparam int LONG_W  = WORD_W - 2;
    localparam int OFF_LSB = SHORT_W;
    localparam int OFF_MSB = SHORT_W + OFF_W - 1;

    logic [OFF_W-1:0] off_field;

    assign off_field = word[OFF_MSB:OFF_LSB];

    always_comb begin
        desc = '0;
        if (!map_en) begin
            desc.count = word;
        end else begin
            desc.src_en = word[WORD_W-1];
            desc.dst_en = word[WORD_W-2];
            if (word[WORD_W-1] || word[WORD_W-2]) begin
                desc.offset = {{(ADDR_W-OFF_W){off_field[OFF_W-1]}}, off_field};
                desc.count  = {{(WORD_W-SHORT_W){1'b0}}, word[SHORT_W-1:0]};
            end else begin
                desc.count  = {2'b00, word[LONG_W-1:0]};
            end
        end
    end
endmodule

// File: rtl/mloop_beat_calc.sv
module mloop_beat_calc
    import mloop_pkg::*;
#(
    parameter int BEAT_BYTES = 4,
    parameter int SZ_W       = $clog2(BEAT_BYTES) + 1
) (
    input  logic [WORD_W-1:0] remaining,
    output logic [SZ_W-1:0]   beat,
    output logic              last
);
    localparam logic [WORD_W-1:0] FULL = WORD_W'(BEAT_BYTES);

    always_comb begin
        if (remaining >= FULL) begin
            beat = SZ_W'(BEAT_BYTES);
        end else begin
            beat = remaining[SZ_W-1:0];
        end
        last = (remaining <= FULL);
    end
endmodule

// File: rtl/mloop_cancel_ctl.sv
module mloop_cancel_ctl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cancel_set,
    input  logic       err_cancel_set,
    input  logic       err_clr,
    input  logic       err_int_en,
    input  logic       idle,
    input  logic       honor,
    output logic       stop_req,
    output logic [1:0] pending,
    output logic       err_status,
    output logic       err_irq
);
    logic cx_q, ecx_q, err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cx_q  <= 1'b0;
            ecx_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            if (cancel_set)          cx_q <= 1'b1;
            else if (idle || honor)  cx_q <= 1'b0;

            if (err_cancel_set)      ecx_q <= 1'b1;
            else if (idle || honor)  ecx_q <= 1'b0;

            if (honor && ecx_q)      err_q <= 1'b1;
            else if (err_clr)        err_q <= 1'b0;
        end
    end

    assign stop_req   = cx_q || ecx_q;
    assign pending    = {ecx_q, cx_q};
    assign err_status = err_q;
    assign err_irq    = err_q && err_int_en;

    a_r9_error_cancel_logged: assert property (@(posedge clk) disable iff (!rst_n)
        (honor && ecx_q) |=> err_q);
    a_r9_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> err_q);
    a_r10_idle_cancel_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !cancel_set && !err_cancel_set) |=> (!cx_q && !ecx_q));
    a_r12_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !err_clr) |=> err_q);
    a_r8_cancel_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (honor && !cancel_set && !err_cancel_set) |=> (!cx_q && !ecx_q));
endmodule

// File: rtl/mloop_dma.sv
module mloop_dma
    import mloop_pkg::*;
#(
    parameter int BEAT_BYTES = 4,
    parameter int OFF_W      = 20,
    parameter int SHORT_W    = 10,
    parameter int DATA_W     = 8 * BEAT_BYTES,
    parameter int SZ_W       = $clog2(BEAT_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              map_en,
    input  logic [WORD_W-1:0] desc_word,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic              cancel_set,
    input  logic              err_cancel_set,
    input  logic              err_clr,
    input  logic              err_int_en,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [SZ_W-1:0]   rd_size,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [SZ_W-1:0]   wr_size,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ack,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [1:0]        cancel_pending,
    output logic              err_status,
    output logic              err_irq
);
    mloop_state_e      state_q, state_d;
    mloop_desc_t       dec;
    logic [ADDR_W-1:0] src_q, dst_q, off_q;
    logic [WORD_W-1:0] rem_q;
    logic              src_en_q, dst_en_q;
    logic [DATA_W-1:0] data_q;
    logic [SZ_W-1:0]   beat;
    logic              last_beat;
    logic              stop_req;
    logic              in_idle, in_finish;

    mloop_desc_decode #(.OFF_W(OFF_W), .SHORT_W(SHORT_W)) u_decode (
        .map_en (map_en),
        .word   (desc_word),
        .desc   (dec)
    );

    mloop_beat_calc #(.BEAT_BYTES(BEAT_BYTES), .SZ_W(SZ_W)) u_beat (
        .remaining (rem_q),
        .beat      (beat),
        .last      (last_beat)
    );

    assign in_idle   = (state_q == ST_IDLE);
    assign in_finish = (state_q == ST_FINISH);

    mloop_cancel_ctl u_cancel (
        .clk            (clk),
        .rst_n          (rst_n),
        .cancel_set     (cancel_set),
        .err_cancel_set (err_cancel_set),
        .err_clr        (err_clr),
        .err_int_en     (err_int_en),
        .idle           (in_idle),
        .honor          (in_finish),
        .stop_req       (stop_req),
        .pending        (cancel_pending),
        .err_status     (err_status),
        .err_irq        (err_irq)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = (dec.count == '0) ? ST_FINISH : ST_READ;
            end
            ST_READ: begin
                if (rd_ack) state_d = ST_WRITE;
            end
            ST_WRITE: begin
                if (wr_ack) state_d = (last_beat || stop_req) ? ST_FINISH : ST_READ;
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // loop datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q    <= '0;
            dst_q    <= '0;
            off_q    <= '0;
            rem_q    <= '0;
            src_en_q <= 1'b0;
            dst_en_q <= 1'b0;
            data_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        src_q    <= src_base;
                        dst_q    <= dst_base;
                        off_q    <= dec.offset;
                        rem_q    <= dec.count;
                        src_en_q <= dec.src_en;
                        dst_en_q <= dec.dst_en;
                    end
                end
                ST_READ: begin
                    if (rd_ack) data_q <= rd_data;
                end
                ST_WRITE: begin
                    if (wr_ack) begin
                        src_q <= src_q + ADDR_W'(beat);
                        dst_q <= dst_q + ADDR_W'(beat);
                        rem_q <= rem_q - WORD_W'(beat);
                    end
                end
                ST_FINISH: begin
                    if (src_en_q) src_q <= src_q + off_q;
                    if (dst_en_q) dst_q <= dst_q + off_q;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        rd_req   = (state_q == ST_READ);
        wr_req   = (state_q == ST_WRITE);
        done     = in_finish;
        busy     = !in_idle;
        rd_addr  = src_q;
        wr_addr  = dst_q;
        rd_size  = beat;
        wr_size  = beat;
        wr_data  = data_q;
        src_addr = src_q;
        dst_addr = dst_q;
    end

    a_r1_one_activity: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_req, wr_req, done}));
    a_r5_beat_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_size != '0 && rd_size <= SZ_W'(BEAT_BYTES)));
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r13_read_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));
    a_r13_write_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr)));
    a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && start && !rd_ack) |=> (rd_req && $stable(rd_addr)));
endmodule

// File: tb/mloop_dma_test.sv
`timescale 1ns/1ps
module mloop_dma_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, map_en = 1'b0;
    logic [31:0] desc_word = '0, src_base = '0, dst_base = '0;
    logic        cancel_set = 1'b0, err_cancel_set = 1'b0, err_clr = 1'b0, err_int_en = 1'b0;
    logic        rd_req, wr_req, busy, done, err_status, err_irq;
    logic [31:0] rd_addr, wr_addr, wr_data, src_addr, dst_addr;
    logic [2:0]  rd_size, wr_size;
    logic        rd_ack = 1'b0, wr_ack = 1'b0;
    logic [31:0] rd_data = '0;
    logic [1:0]  cancel_pending;

    int checks = 0, fails = 0, cyc = 0, rd_seen = 0;
    logic       ack_now = 1'b0;
    logic [7:0] lfsr = 8'h5B;

    always #2 clk = ~clk;

    mloop_dma uut (.*);

    // reference model state
    int          m_state = 0;
    logic [31:0] m_src = 0, m_dst = 0, m_rem = 0, m_off = 0, m_data = 0;
    logic        m_sen = 0, m_den = 0, m_cx = 0, m_ecx = 0, m_err = 0;

    function automatic logic [31:0] beat_of(input logic [31:0] r);
        return (r > 4) ? 32'd4 : r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_src = 0; m_dst = 0; m_rem = 0; m_off = 0; m_data = 0;
            m_sen = 0; m_den = 0; m_cx = 0; m_ecx = 0; m_err = 0;
        end else begin
            logic [31:0] b;
            logic nc, ne, nerr;
            b    = beat_of(m_rem);
            nc   = cancel_set     ? 1'b1 : ((m_state == 0 || m_state == 3) ? 1'b0 : m_cx);
            ne   = err_cancel_set ? 1'b1 : ((m_state == 0 || m_state == 3) ? 1'b0 : m_ecx);
            nerr = (m_state == 3 && m_ecx) ? 1'b1 : (err_clr ? 1'b0 : m_err);
            case (m_state)
                0: if (start) begin
                    int o;
                    m_src = src_base; m_dst = dst_base; m_off = 0;
                    m_sen = 0; m_den = 0;
                    if (!map_en) m_rem = desc_word;
                    else begin
                        m_sen = desc_word[31]; m_den = desc_word[30];
                        if (m_sen || m_den) begin
                            o = int'(desc_word[29:10]);
                            if (o >= 524288) o = o - 1048576;
                            m_off = o;
                            m_rem = desc_word % 1024;
                        end else m_rem = desc_word % (1 << 30);
                    end
                    m_state = (m_rem == 0) ? 3 : 1;
                end
                1: if (rd_ack) begin m_data = rd_data; m_state = 2; end
                2: if (wr_ack) begin
                    m_state = (m_rem == b || m_cx || m_ecx) ? 3 : 1;
                    m_src = m_src + b; m_dst = m_dst + b; m_rem = m_rem - b;
                end
                default: begin
                    if (m_sen) m_src = m_src + m_off;
                    if (m_den) m_dst = m_dst + m_off;
                    m_state = 0;
                end
            endcase
            m_cx = nc; m_ecx = ne; m_err = nerr;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rd_req) rd_seen++;
        chk("R7 busy", {31'd0, busy}, {31'd0, m_state != 0});
        chk("R7 done", {31'd0, done}, {31'd0, m_state == 3});
        chk("R13 rd_req", {31'd0, rd_req}, {31'd0, m_state == 1});
        chk("R13 wr_req", {31'd0, wr_req}, {31'd0, m_state == 2});
        chk("R5 rd_addr", rd_addr, m_src);
        chk("R5 wr_addr", wr_addr, m_dst);
        if (rd_req || wr_req) begin
            chk("R5 rd_size", {29'd0, rd_size}, beat_of(m_rem));
            chk("R5 wr_size", {29'd0, wr_size}, beat_of(m_rem));
        end
        if (wr_req) chk("R5 wr_data", wr_data, m_data);
        chk("R3 src_addr", src_addr, m_src);
        chk("R3 dst_addr", dst_addr, m_dst);
        chk("R9 err_status", {31'd0, err_status}, {31'd0, m_err});
        chk("R9 err_irq", {31'd0, err_irq}, {31'd0, m_err && err_int_en});
        chk("R10 cancel bits", {30'd0, cancel_pending}, {30'd0, m_ecx, m_cx});
    end

    // memory-side responder
    always @(negedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        rd_ack  <= rd_req && (ack_now || lfsr[0]);
        wr_ack  <= wr_req && (ack_now || lfsr[3]);
        rd_data <= 32'hC3A50000 ^ cyc;
    end

    task automatic go(input logic mp, input logic [31:0] w, input logic [31:0] s, input logic [31:0] d);
        @(negedge clk);
        map_en = mp; desc_word = w; src_base = s; dst_base = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected fewer", cyc);
            summary();
        end
    end

    initial begin
        int r0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", {31'd0, busy}, 0);
        chk("R1 rd_req", {31'd0, rd_req}, 0);
        chk("R1 err_status", {31'd0, err_status}, 0);
        chk("R1 cancel bits", {30'd0, cancel_pending}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 plain count
        go(1'b0, 32'd13, 32'h1000, 32'h2000); wait_done();
        chk("R2 src end", src_addr, 32'h100D);
        chk("R2 dst end", dst_addr, 32'h200D);

        // R3 source offset only, negative
        go(1'b1, {1'b1, 1'b0, 20'hFFFC0, 10'd9}, 32'h3000, 32'h4000); wait_done();
        chk("R3 src offset", src_addr, 32'h3000 + 9 - 32'h40);
        chk("R3 dst no offset", dst_addr, 32'h4009);

        // R3 destination only, positive
        go(1'b1, {1'b0, 1'b1, 20'h00100, 10'd8}, 32'h5000, 32'h6000); wait_done();
        chk("R3 src no offset", src_addr, 32'h5008);
        chk("R3 dst offset", dst_addr, 32'h6108);

        // R3 both sides
        go(1'b1, {1'b1, 1'b1, 20'h00010, 10'd6}, 32'h7000, 32'h8000); wait_done();
        chk("R3 src both", src_addr, 32'h7016);
        chk("R3 dst both", dst_addr, 32'h8016);

        // R4 mapping on, no enables: long count uses bits above 9
        go(1'b1, {2'b00, 30'h405}, 32'h9000, 32'hA000); wait_done();
        chk("R4 src long", src_addr, 32'h9405);
        chk("R4 dst long", dst_addr, 32'hA405);

        // R6 zero count
        r0 = rd_seen;
        go(1'b1, {1'b1, 1'b0, 20'h00010, 10'd0}, 32'hB000, 32'hC000);
        chk("R6 done next cycle", {31'd0, done}, 1);
        wait_done();
        chk("R6 no reads", rd_seen - r0, 0);
        chk("R6 offset applied", src_addr, 32'hB010);

        // R8 normal cancel mid loop
        go(1'b0, 32'd64, 32'h10000, 32'h20000);
        repeat (12) @(negedge clk);
        cancel_set = 1'b1; @(negedge clk); cancel_set = 1'b0;
        wait_done();
        chk("R8 stopped early", {31'd0, (src_addr - 32'h10000) < 64}, 1);
        chk("R8 word boundary", (src_addr - 32'h10000) % 4, 0);
        chk("R8 no error", {31'd0, err_status}, 0);
        chk("R8 bits cleared", {30'd0, cancel_pending}, 0);

        // R9 error cancel with interrupt enabled
        err_int_en = 1'b1;
        go(1'b0, 32'd40, 32'h30000, 32'h40000);
        repeat (8) @(negedge clk);
        err_cancel_set = 1'b1; @(negedge clk); err_cancel_set = 1'b0;
        wait_done();
        chk("R9 error set", {31'd0, err_status}, 1);
        chk("R9 irq high", {31'd0, err_irq}, 1);
        err_int_en = 1'b0; @(negedge clk);
        chk("R9 irq masked", {31'd0, err_irq}, 0);
        err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
        chk("R12 cleared by pulse", {31'd0, err_status}, 0);

        // R10 cancel while idle
        cancel_set = 1'b1; err_cancel_set = 1'b1; @(negedge clk);
        cancel_set = 1'b0; err_cancel_set = 1'b0;
        chk("R10 bits visible", {30'd0, cancel_pending}, 3);
        @(negedge clk);
        chk("R10 bits dropped", {30'd0, cancel_pending}, 0);
        go(1'b0, 32'd8, 32'h50000, 32'h60000); wait_done();
        chk("R10 full loop", src_addr, 32'h50008);
        chk("R10 no error", {31'd0, err_status}, 0);

        // R11 start while busy
        go(1'b0, 32'd20, 32'h70000, 32'h80000);
        repeat (4) @(negedge clk);
        desc_word = 32'd4; src_base = 32'hF0000; start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_done();
        chk("R11 src unchanged", src_addr, 32'h70014);
        chk("R11 dst unchanged", dst_addr, 32'h80014);

        // R9/R12 coincidences: error cancel on final write ack, clear in finish
        ack_now = 1'b1;
        go(1'b0, 32'd4, 32'h90000, 32'hA0000);
        while (!wr_req) @(negedge clk);
        err_cancel_set = 1'b1; @(negedge clk); err_cancel_set = 1'b0;
        chk("R9 finish after last ack", {31'd0, done}, 1);
        err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
        chk("R9 error on final ack", {31'd0, err_status}, 1);
        chk("R12 set beats clear", {31'd0, err_status}, 1);
        chk("R9 moved one beat", src_addr, 32'h90004);
        err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
        chk("R12 cleared", {31'd0, err_status}, 0);
        ack_now = 1'b0;

        repeat (3) @(negedge clk);
        summary();
    end
endmodule